// File: doc/BRIEF.md
# Flash Command Port with Auto-Address Pointer

This block gives a host byte-wide access to a large parallel flash through a small command window on a local bus. The window does not map flash addresses. Each access sets one command bit in the local word address. That bit selects a single operation: clear the internal pointer, step it, read it back, write or read one flash byte at the pointer, reset the flash state machine, or start an erase. The flash address always comes from a 21-bit pointer kept inside the block.

A host accesses the block by pulsing `bus_sel` for one clock with `bus_wr`, `bus_addr` and `bus_wdata` valid. The block answers with a one-clock `bus_ack`. Operations that touch the flash assert the chip enable and one strobe for a fixed number of clocks (`STROBE_CYC`), and only then acknowledge. Pointer operations acknowledge on the next clock.

Top module: `flash_cmd_port`

## Requirements
- R1: After reset the pointer is zero, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, and `bus_ack` is low.
- R2: A write with command bit 2 set clears the pointer to zero. `bus_addr[i]` carries command bit i, for i from 2 to 8.
- R3: A write with command bit 7 set increments the pointer by one and acknowledges one clock after acceptance, with no flash strobe.
- R4: A write with command bit 3 set drives `bus_wdata` onto `fl_dout` at address pointer. `fl_ce_n` and `fl_we_n` stay low for exactly `STROBE_CYC` clocks, and `bus_ack` rises `STROBE_CYC`+1 clocks after acceptance.
- R5: A read with command bit 4 set holds `fl_ce_n` and `fl_oe_n` low for `STROBE_CYC` clocks at address pointer. It returns the `fl_din` byte in `bus_rdata[7:0]` with the upper bits zero.
- R6: A write with command bit 5 set issues one flash write cycle carrying the reset code 0xF0 at the pointer address.
- R7: A write with command bit 6 set issues one flash write cycle carrying the erase code 0x30 at the pointer address.
- R8: A read with command bit 8 set returns the pointer, zero-extended, on `bus_rdata`.
- R9: When several command bits are set, the lowest-numbered set bit alone selects the operation.
- R10: If no command bit is set, or if the selected operation does not match the access direction, the access is acknowledged one clock later and changes neither the pointer nor the flash pins.
- R11: `bus_ack` is high for exactly one clock per access. A `bus_sel` pulse that arrives while a flash strobe is in progress is ignored.
- R12: Incrementing the pointer from all ones gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | One-clock access request |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 7 | Word address bits 8:2, one command bit each |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | DATA_W | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-clock completion pulse |
| fl_addr | output | PTR_W | Flash address (the pointer) |
| fl_dout | output | 8 | Byte driven to the flash |
| fl_din | input | 8 | Byte returned by the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The bench sets several command bits at once. A decoder that let the higher bit win would step the pointer when it should write, or step it when it should clear, and the pointer readback shows the difference. It sends commands in the wrong direction, such as a clear during a read or a byte read during a write. A design that ignored the direction would clear the pointer or pulse a strobe. It pulses a request in the middle of a strobe, where a design without a busy guard would step the pointer. It counts the strobe clocks and the acknowledge latency, so an off-by-one strobe counter shows up. A second instance with a four-bit pointer is stepped past all ones, so it catches a pointer that saturates instead of wrapping.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    // Command bit positions inside the local byte address
    localparam int CMD_LO = 2;
    localparam int CMD_HI = 8;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PCLR  = 3'd1,
        OP_WBYTE = 3'd2,
        OP_RBYTE = 3'd3,
        OP_FRST  = 3'd4,
        OP_ERASE = 3'd5,
        OP_PINC  = 3'd6,
        OP_PREAD = 3'd7
    } op_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_STRB = 1'b1
    } seq_st_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] wbyte;
    } cmd_t;

    function automatic op_e bit_to_op(input int b);
        case (b)
            2:       return OP_PCLR;
            3:       return OP_WBYTE;
            4:       return OP_RBYTE;
            5:       return OP_FRST;
            6:       return OP_ERASE;
            7:       return OP_PINC;
            8:       return OP_PREAD;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic op_is_read(input op_e op);
        return (op == OP_RBYTE) || (op == OP_PREAD);
    endfunction

    function automatic logic op_uses_flash(input op_e op);
        return (op == OP_WBYTE) || (op == OP_RBYTE) ||
               (op == OP_FRST)  || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/flcmd_decode.sv
module flcmd_decode
    import flcmd_pkg::*;
(
    input  logic                 wr,
    input  logic [CMD_HI:CMD_LO] addr,
    output op_e                  op
);
    op_e cand;

    // Scan from the top so that the lowest set bit is written last
    always_comb begin
        cand = OP_NONE;
        for (int b = CMD_HI; b >= CMD_LO; b--) begin
            if (addr[b]) cand = bit_to_op(b);
        end
        if (cand == OP_NONE)
            op = OP_NONE;
        else if (op_is_read(cand) != !wr)
            op = OP_NONE;
        else
            op = cand;
    end

endmodule

// File: rtl/flcmd_ptr.sv
module flcmd_ptr #(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= '0;
        else if (inc)
            ptr <= ptr + 1'b1;
    end

    // R2
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0));

    // R12
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
#(
    parameter int         PTR_W      = 21,
    parameter int         DATA_W     = 24,
    parameter int         STROBE_CYC = 4,
    parameter logic [7:0] RST_CODE   = 8'hF0,
    parameter logic [7:0] ERASE_CODE = 8'h30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  cmd_t              cmd,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [7:0]        fl_din,
    output logic              ptr_clr,
    output logic              ptr_inc,
    output logic [7:0]        fl_dout,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

    seq_st_e          st;
    logic [CNT_W-1:0] cnt;
    logic             take;

    assign take    = (st == S_IDLE) && sel;
    assign ptr_clr = take && (cmd.op == OP_PCLR);
    assign ptr_inc = take && (cmd.op == OP_PINC);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cnt     <= '0;
            fl_dout <= '0;
            fl_ce_n <= 1'b1;
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            ack     <= 1'b0;
            rdata   <= '0;
        end else begin
            ack <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (take) begin
                        if (op_uses_flash(cmd.op)) begin
                            st      <= S_STRB;
                            cnt     <= CNT_LOAD;
                            fl_ce_n <= 1'b0;
                            if (cmd.op == OP_RBYTE) begin
                                fl_oe_n <= 1'b0;
                            end else begin
                                fl_we_n <= 1'b0;
                                case (cmd.op)
                                    OP_FRST:  fl_dout <= RST_CODE;
                                    OP_ERASE: fl_dout <= ERASE_CODE;
                                    default:  fl_dout <= cmd.wbyte;
                                endcase
                            end
                        end else begin
                            ack <= 1'b1;
                            if (cmd.op == OP_PREAD) rdata <= DATA_W'(ptr);
                        end
                    end
                end
                S_STRB: begin
                    if (cnt == '0) begin
                        st      <= S_IDLE;
                        fl_ce_n <= 1'b1;
                        fl_we_n <= 1'b1;
                        fl_oe_n <= 1'b1;
                        ack     <= 1'b1;
                        if (!fl_oe_n) rdata <= DATA_W'(fl_din);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R4
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));

    // R11
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R4
    ack_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (fl_ce_n && fl_we_n && fl_oe_n));

    // R11
    busy_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n) |-> (!ptr_clr && !ptr_inc));

endmodule

// File: rtl/flash_cmd_port.sv
module flash_cmd_port
    import flcmd_pkg::*;
#(
    parameter int         PTR_W      = 21,
    parameter int         DATA_W     = 24,
    parameter int         STROBE_CYC = 4,
    parameter logic [7:0] RST_CODE   = 8'hF0,
    parameter logic [7:0] ERASE_CODE = 8'h30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [CMD_HI:CMD_LO] bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_ack,
    output logic [PTR_W-1:0]     fl_addr,
    output logic [7:0]           fl_dout,
    input  logic [7:0]           fl_din,
    output logic                 fl_ce_n,
    output logic                 fl_we_n,
    output logic                 fl_oe_n
);
    op_e              dec_op;
    cmd_t             cmd;
    logic             p_clr;
    logic             p_inc;
    logic [PTR_W-1:0] ptr;

    flcmd_decode u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .op   (dec_op)
    );

    assign cmd.op    = dec_op;
    assign cmd.wbyte = bus_wdata;

    flcmd_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk (clk),
        .rst (rst),
        .clr (p_clr),
        .inc (p_inc),
        .ptr (ptr)
    );

    flcmd_seq #(
        .PTR_W      (PTR_W),
        .DATA_W     (DATA_W),
        .STROBE_CYC (STROBE_CYC),
        .RST_CODE   (RST_CODE),
        .ERASE_CODE (ERASE_CODE)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .cmd     (cmd),
        .ptr     (ptr),
        .fl_din  (fl_din),
        .ptr_clr (p_clr),
        .ptr_inc (p_inc),
        .fl_dout (fl_dout),
        .fl_ce_n (fl_ce_n),
        .fl_we_n (fl_we_n),
        .fl_oe_n (fl_oe_n),
        .ack     (bus_ack),
        .rdata   (bus_rdata)
    );

    assign fl_addr = ptr;

    // R4
    fl_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

endmodule

// File: tb/sim_flash_cmd_port.sv
module sim_flash_cmd_port;
    localparam int N  = 4;
    localparam int PW = 21;
    localparam int DW = 24;

    typedef struct packed {
        logic        wr;
        logic [8:0]  addr;
        logic [7:0]  wd;
        logic [7:0]  din;
        logic        s_we;
        logic        s_oe;
        logic [7:0]  dout;
        logic [20:0] faddr;
        logic        chk_rd;
        logic [23:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 9'h080, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b0, 24'h0,    4'd3},  // R3 -> 1
        '{1'b1, 9'h080, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b0, 24'h0,    4'd3},  // R3 -> 2
        '{1'b0, 9'h100, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b1, 24'h2,    4'd8},  // R8
        '{1'b1, 9'h008, 8'hC3, 8'h00, 1'b1, 1'b0, 8'hC3, 21'd2, 1'b0, 24'h0,    4'd4},  // R4
        '{1'b0, 9'h010, 8'h00, 8'h5A, 1'b0, 1'b1, 8'h00, 21'd2, 1'b1, 24'h5A,   4'd5},  // R5
        '{1'b1, 9'h020, 8'h11, 8'h00, 1'b1, 1'b0, 8'hF0, 21'd2, 1'b0, 24'h0,    4'd6},  // R6
        '{1'b1, 9'h040, 8'h22, 8'h00, 1'b1, 1'b0, 8'h30, 21'd2, 1'b0, 24'h0,    4'd7},  // R7
        '{1'b1, 9'h088, 8'h77, 8'h00, 1'b1, 1'b0, 8'h77, 21'd2, 1'b0, 24'h0,    4'd9},  // R9 write beats inc
        '{1'b0, 9'h100, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b1, 24'h2,    4'd9},  // R9 ptr not stepped
        '{1'b1, 9'h084, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b0, 24'h0,    4'd9},  // R9 clear beats inc
        '{1'b0, 9'h100, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b1, 24'h0,    4'd2},  // R2
        '{1'b1, 9'h080, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b0, 24'h0,    4'd3},  // R3 -> 1
        '{1'b1, 9'h000, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b0, 24'h0,    4'd10}, // R10 no bit
        '{1'b0, 9'h004, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b0, 24'h0,    4'd10}, // R10 clear on read
        '{1'b1, 9'h010, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b0, 24'h0,    4'd10}, // R10 byte read on write
        '{1'b0, 9'h100, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 21'd0, 1'b1, 24'h1,    4'd10}, // R10 ptr kept
        '{1'b0, 9'h110, 8'h00, 8'h3C, 1'b0, 1'b1, 8'h00, 21'd1, 1'b1, 24'h3C,   4'd9}   // R9 byte read beats ptr read
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [8:2]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    din = '0;
    logic [DW-1:0] rdata;
    logic          ack;
    logic [PW-1:0] faddr;
    logic [7:0]    dout;
    logic          ce_n, we_n, oe_n;

    logic          sel1 = 1'b0;
    logic          wr1 = 1'b0;
    logic [8:2]    addr1 = '0;
    logic [DW-1:0] rdata1;
    logic          ack1;
    logic [3:0]    faddr1;
    logic [7:0]    dout1;
    logic          ce1, we1, oe1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    flash_cmd_port #(.PTR_W(PW), .DATA_W(DW), .STROBE_CYC(N)) u0 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack), .fl_addr(faddr),
        .fl_dout(dout), .fl_din(din), .fl_ce_n(ce_n), .fl_we_n(we_n), .fl_oe_n(oe_n)
    );

    flash_cmd_port #(.PTR_W(4), .DATA_W(DW), .STROBE_CYC(N)) u1 (
        .clk(clk), .rst(rst), .bus_sel(sel1), .bus_wr(wr1), .bus_addr(addr1),
        .bus_wdata(8'h00), .bus_rdata(rdata1), .bus_ack(ack1), .fl_addr(faddr1),
        .fl_dout(dout1), .fl_din(8'h00), .fl_ce_n(ce1), .fl_we_n(we1), .fl_oe_n(oe1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [8:0] a, input logic [7:0] wd,
                       input logic [7:0] fd, output logic [23:0] rd, output int lat,
                       output int wec, output int oec, output logic [7:0] dseen,
                       output logic [20:0] aseen, output int ackc);
        rd = '0; lat = 0; wec = 0; oec = 0; dseen = '0; aseen = '0; ackc = 0;
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a[8:2]; wdata = wd; din = fd;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            sel = 1'b0;
            lat++;
            if (!we_n) begin wec++; dseen = dout; aseen = faddr; end
            if (!oe_n) begin oec++; aseen = faddr; end
            if (ack) begin rd = rdata; ackc++; break; end
        end
        @(negedge clk);
        if (ack) ackc++;
    endtask

    task automatic acc1(input logic w, input logic [8:0] a, output logic [23:0] rd);
        @(negedge clk);
        sel1 = 1'b1; wr1 = w; addr1 = a[8:2];
        @(negedge clk);
        sel1 = 1'b0;
        rd = rdata1;
        chk(ack1 == 1'b1, "R12", "ack1 one clock after request", 32'(ack1), 32'd1);
    endtask

    initial begin
        logic [23:0] rd;
        logic [7:0]  ds;
        logic [20:0] as;
        int lat, wec, oec, ackc;
        string rq;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce_n && we_n && oe_n, "R1", "strobes idle in reset", {29'd0, ce_n, we_n, oe_n}, 32'h7);
        chk(ack == 1'b0, "R1", "ack low in reset", 32'(ack), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(ce_n && we_n && oe_n, "R1", "strobes idle after reset", {29'd0, ce_n, we_n, oe_n}, 32'h7);
        acc(1'b0, 9'h100, 8'h00, 8'h00, rd, lat, wec, oec, ds, as, ackc);
        chk(rd == 24'h0, "R1", "pointer zero after reset", 32'(rd), 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v  = VECS[i];
            rq = $sformatf("R%0d", v.req);
            acc(v.wr, v.addr, v.wd, v.din, rd, lat, wec, oec, ds, as, ackc);
            chk(lat == ((v.s_we || v.s_oe) ? N + 1 : 1), rq, $sformatf("vec %0d ack latency", i),
                32'(lat), 32'((v.s_we || v.s_oe) ? N + 1 : 1));
            chk(wec == (v.s_we ? N : 0), rq, $sformatf("vec %0d write strobe clocks", i),
                32'(wec), 32'(v.s_we ? N : 0));
            chk(oec == (v.s_oe ? N : 0), rq, $sformatf("vec %0d read strobe clocks", i),
                32'(oec), 32'(v.s_oe ? N : 0));
            chk(ackc == 1, "R11", $sformatf("vec %0d ack pulse width", i), 32'(ackc), 32'd1);
            if (v.s_we)
                chk(ds == v.dout, rq, $sformatf("vec %0d flash data", i), 32'(ds), 32'(v.dout));
            if (v.s_we || v.s_oe)
                chk(as == v.faddr, rq, $sformatf("vec %0d flash address", i), 32'(as), 32'(v.faddr));
            if (v.chk_rd)
                chk(rd == v.rd, rq, $sformatf("vec %0d read data", i), 32'(rd), 32'(v.rd));
        end

        // R11: request during a strobe is ignored (pointer is 1 here)
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 7'(9'h008 >> 2); wdata = 8'h99;
        @(negedge clk);
        sel = 1'b0;
        @(negedge clk);
        sel = 1'b1; addr = 7'(9'h080 >> 2);
        @(negedge clk);
        sel = 1'b0;
        repeat (N + 2) @(negedge clk);
        acc(1'b0, 9'h100, 8'h00, 8'h00, rd, lat, wec, oec, ds, as, ackc);
        chk(rd == 24'h1, "R11", "request during strobe ignored", 32'(rd), 32'd1);

        // R12: wrap on a four-bit pointer
        for (int k = 0; k < 15; k++) acc1(1'b1, 9'h080, rd);
        acc1(1'b0, 9'h100, rd);
        chk(rd == 24'hF, "R12", "pointer reaches all ones", 32'(rd), 32'hF);
        acc1(1'b1, 9'h080, rd);
        acc1(1'b0, 9'h100, rd);
        chk(rd == 24'h0, "R12", "pointer wraps to zero", 32'(rd), 32'h0);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule